// File: doc/BRIEF.md
# Reciprocal Square Root Seed Unit

This unit takes one IEEE-754 single-precision operand per accepted cycle and returns a coarse starting estimate of 1/sqrt(x), packed as a single-precision word, along with an invalid indication. The estimate is meant to seed an iterative refinement step that sits elsewhere. It is not accurate on its own.

For a positive normal operand, the result exponent is computed by arithmetic. The top eight fraction bits of the result come from a 128-entry table of 8-bit values. The table is indexed by the parity of the biased exponent minus one, together with the six leading fraction bits of the operand. Every other operand class gets a fixed code: NaN, zero or denormal, negative, and positive infinity. The operand is first sorted into one of five classes with a fixed priority: `CLS_NAN`, `CLS_TINY`, `CLS_NEG`, `CLS_INF` and `CLS_NORM`. A `unique case` on that class selects the result.

The interface is a plain valid-in / valid-out pair with one register stage. The registered output has two behaviours. The HOLD behaviour applies when no operand is presented: the result stays where it is. The LOAD behaviour applies when an operand is presented: the result updates on the next edge.

Top module: `rsq_seed`

## Requirements
- R1: An operand with exponent field 0xFF and a non-zero fraction (any sign) yields 0x7FC00000.
- R2: An operand with exponent field 0x00 (zero or denormal) yields infinity carrying the operand's sign: 0x7F800000 for sign 0, 0xFF800000 for sign 1.
- R3: Any other operand with sign bit 1, including negative infinity, yields 0x7FC00004.
- R4: Positive infinity (0x7F800000) yields 0x00000000.
- R5: A positive normal operand with biased exponent E produces a result with the following fields:
  - sign bit 31 = 0;
  - exponent bits [30:23] = 0xBD − ((E−1) >> 1);
  - bits [22:15] = the table entry at index {(E−1) bit 0, operand bits [22:17]}, where the parity bit is the index MSB;
  - bits [14:0] = 0.
- R6: The table entry at each even index 2k is odd, and the entry at index 2k+1 equals it minus one. Specific entries are: index 0 → 253, 1 → 252, 2 → 245, 3 → 244, 48 → 131, 63 → 108, 64 → 103, 65 → 102, 126 → 3, 127 → 2.
- R7: `out_invalid` is 1 exactly when the operand is a signalling NaN (exponent 0xFF, non-zero fraction, bit 22 = 0) or when the result is 0x7FC00004. Otherwise it is 0.
- R8: `out_valid` is 1 in the cycle after each cycle with `in_valid` = 1, and 0 otherwise. Back-to-back operands produce back-to-back results.
- R9: While `in_valid` is 0, `out_res` and `out_invalid` keep their previous values, whatever `in_op` carries.
- R10: After reset, `out_valid`, `out_res` and `out_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 32 | Single-precision seed result |
| out_invalid | output | 1 | Invalid-operation indication for the result |

## Verification
There is only one register stage, so any fault in the class decode, table or exponent arithmetic shows up on `out_res` in the very next cycle after the offending operand. The stimulus includes one operand from every class, plus normal operands that hit both exponent parities and the first, middle and last table entries. A wrong class priority would surface as the wrong fixed code; a negative NaN and a negative denormal are included to separate these cases. A broken HOLD path would show as `out_res` drifting during idle cycles that carry a deliberately hostile `in_op`, and the bench compares against the last expected result in every such cycle.

// File: rtl/rsq_seed_pkg.sv
package rsq_seed_pkg;
    localparam int EXP_W      = 8;
    localparam int FRAC_W     = 23;
    localparam int WORD_W     = 1 + EXP_W + FRAC_W;
    localparam int IDX_FRAC_W = 6;
    localparam int IDX_W      = IDX_FRAC_W + 1;
    localparam int ENTRY_W    = 8;
    localparam int PAIR_W     = IDX_W - 1;
    localparam int HALF_W     = ENTRY_W - 1;
    localparam int LOW_ZERO_W = FRAC_W - ENTRY_W;

    localparam logic [EXP_W-1:0]  EXP_ALL_ONE = '1;
    localparam logic [EXP_W-1:0]  SEED_EXP_BASE = 8'hBD;
    localparam logic [WORD_W-1:0] CODE_QNAN    = 32'h7FC0_0000;
    localparam logic [WORD_W-1:0] CODE_NEG_NAN = 32'h7FC0_0004;
    localparam logic [WORD_W-1:0] CODE_POS_INF = 32'h7F80_0000;

    typedef enum logic [2:0] {
        CLS_NAN  = 3'd0,
        CLS_TINY = 3'd1,
        CLS_NEG  = 3'd2,
        CLS_INF  = 3'd3,
        CLS_NORM = 3'd4
    } op_class_e;
endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
    import rsq_seed_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    output op_class_e         cls,
    output logic              is_snan
);
    logic             sgn;
    logic [EXP_W-1:0] expf;
    logic [FRAC_W-1:0] frac;
    logic             exp_max;
    logic             frac_nz;

    assign sgn     = op[WORD_W-1];
    assign expf    = op[WORD_W-2 -: EXP_W];
    assign frac    = op[FRAC_W-1:0];
    assign exp_max = (expf == EXP_ALL_ONE);
    assign frac_nz = |frac;
    assign is_snan = exp_max && frac_nz && !frac[FRAC_W-1];

    // Priority: NaN, then zero/denormal, then negative, then infinity.
    always_comb begin
        if (exp_max && frac_nz)       cls = CLS_NAN;
        else if (expf == '0)          cls = CLS_TINY;
        else if (sgn)                 cls = CLS_NEG;
        else if (exp_max)             cls = CLS_INF;
        else                          cls = CLS_NORM;
    end
endmodule

// File: rtl/rsq_seed_rom.sv
module rsq_seed_rom
    import rsq_seed_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    output logic [ENTRY_W-1:0] entry
);
    // Entries come in pairs {odd v, v-1}; only (v-1)/2 of each pair is stored.
    logic [HALF_W-1:0] half_v;

    always_comb begin
        unique case (idx[IDX_W-1:1])
            6'd0:  half_v = 7'd126;  6'd1:  half_v = 7'd122;
            6'd2:  half_v = 7'd119;  6'd3:  half_v = 7'd115;
            6'd4:  half_v = 7'd112;  6'd5:  half_v = 7'd108;
            6'd6:  half_v = 7'd105;  6'd7:  half_v = 7'd102;
            6'd8:  half_v = 7'd100;  6'd9:  half_v = 7'd97;
            6'd10: half_v = 7'd94;   6'd11: half_v = 7'd92;
            6'd12: half_v = 7'd89;   6'd13: half_v = 7'd87;
            6'd14: half_v = 7'd84;   6'd15: half_v = 7'd82;
            6'd16: half_v = 7'd80;   6'd17: half_v = 7'd78;
            6'd18: half_v = 7'd76;   6'd19: half_v = 7'd74;
            6'd20: half_v = 7'd72;   6'd21: half_v = 7'd70;
            6'd22: half_v = 7'd68;   6'd23: half_v = 7'd66;
            6'd24: half_v = 7'd65;   6'd25: half_v = 7'd63;
            6'd26: half_v = 7'd61;   6'd27: half_v = 7'd60;
            6'd28: half_v = 7'd58;   6'd29: half_v = 7'd57;
            6'd30: half_v = 7'd55;   6'd31: half_v = 7'd54;
            6'd32: half_v = 7'd51;   6'd33: half_v = 7'd49;
            6'd34: half_v = 7'd46;   6'd35: half_v = 7'd44;
            6'd36: half_v = 7'd41;   6'd37: half_v = 7'd39;
            6'd38: half_v = 7'd37;   6'd39: half_v = 7'd35;
            6'd40: half_v = 7'd33;   6'd41: half_v = 7'd31;
            6'd42: half_v = 7'd29;   6'd43: half_v = 7'd27;
            6'd44: half_v = 7'd26;   6'd45: half_v = 7'd24;
            6'd46: half_v = 7'd22;   6'd47: half_v = 7'd21;
            6'd48: half_v = 7'd19;   6'd49: half_v = 7'd18;
            6'd50: half_v = 7'd16;   6'd51: half_v = 7'd15;
            6'd52: half_v = 7'd13;   6'd53: half_v = 7'd12;
            6'd54: half_v = 7'd11;   6'd55: half_v = 7'd9;
            6'd56: half_v = 7'd8;    6'd57: half_v = 7'd7;
            6'd58: half_v = 7'd6;    6'd59: half_v = 7'd5;
            6'd60: half_v = 7'd4;    6'd61: half_v = 7'd3;
            6'd62: half_v = 7'd2;    6'd63: half_v = 7'd1;
            default: half_v = '0;
        endcase
    end

    assign entry = {half_v, ~idx[0]};
endmodule

// File: rtl/rsq_seed.sv
module rsq_seed
    import rsq_seed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_op,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_res,
    output logic              out_invalid
);
    op_class_e          cls;
    logic               is_snan;
    logic [EXP_W-1:0]   exp_m1;
    logic [EXP_W-1:0]   seed_exp;
    logic [IDX_W-1:0]   tbl_idx;
    logic [ENTRY_W-1:0] tbl_entry;
    logic [WORD_W-1:0]  nxt_res;
    logic               nxt_inv;

    rsq_classify u_cls (
        .op      (in_op),
        .cls     (cls),
        .is_snan (is_snan)
    );

    assign exp_m1   = in_op[WORD_W-2 -: EXP_W] - 1'b1;
    assign seed_exp = SEED_EXP_BASE - {1'b0, exp_m1[EXP_W-1:1]};
    assign tbl_idx  = {exp_m1[0], in_op[FRAC_W-1 -: IDX_FRAC_W]};

    rsq_seed_rom u_rom (
        .idx   (tbl_idx),
        .entry (tbl_entry)
    );

    // Result selection by operand class.
    always_comb begin
        unique case (cls)
            CLS_NAN:  nxt_res = CODE_QNAN;
            CLS_TINY: nxt_res = {in_op[WORD_W-1], CODE_POS_INF[WORD_W-2:0]};
            CLS_NEG:  nxt_res = CODE_NEG_NAN;
            CLS_INF:  nxt_res = '0;
            CLS_NORM: nxt_res = {1'b0, seed_exp, tbl_entry, {LOW_ZERO_W{1'b0}}};
            default:  nxt_res = CODE_QNAN;
        endcase
        nxt_inv = is_snan || (cls == CLS_NEG);
    end

    // Output register: LOAD on in_valid, HOLD otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_res     <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res     <= nxt_res;
                out_invalid <= nxt_inv;
            end
        end
    end
endmodule

// File: rtl/rsq_seed_chk.sv
module rsq_seed_chk
    import rsq_seed_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_op,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_res,
    input logic              out_invalid
);
    logic in_nan, in_negnum, in_posinf, in_posnorm;
    assign in_nan     = (in_op[30:23] == 8'hFF) && (in_op[22:0] != '0);
    assign in_negnum  = in_op[31] && (in_op[30:23] != 8'h00) && !in_nan;
    assign in_posinf  = (in_op == 32'h7F80_0000);
    assign in_posnorm = !in_op[31] && (in_op[30:23] != 8'h00) && (in_op[30:23] != 8'hFF);

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_nan_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nan) |=> (out_res == 32'h7FC0_0000));
    a_r3_neg_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_negnum) |=> (out_res == 32'h7FC0_0004) && out_invalid);
    a_r4_posinf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_posinf) |=> (out_res == '0) && !out_invalid);
    a_r5_norm_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_posnorm) |=> !out_res[31] && (out_res[14:0] == '0) && !out_invalid);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res) && $stable(out_invalid));
endmodule

bind rsq_seed rsq_seed_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .out_valid   (out_valid),
    .out_res     (out_res),
    .out_invalid (out_invalid)
);

// File: tb/rsq_seed_tb_top.sv
module rsq_seed_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_op = '0;
    logic        out_valid;
    logic [31:0] out_res;
    logic        out_invalid;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_res_q[$];
    logic        exp_inv_q[$];
    string       tag_q[$];
    logic [31:0] last_res = '0;
    logic        last_inv = 1'b0;

    always #5 clk = ~clk;

    rsq_seed dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .out_valid(out_valid), .out_res(out_res), .out_invalid(out_invalid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] op, input logic [31:0] res, input logic inv, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        exp_res_q.push_back(res);
        exp_inv_q.push_back(inv);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op    = 32'hBF80_0000 ^ i;   // hostile data while idle
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (out_valid) begin
                    if (exp_res_q.size() == 0) begin
                        check(1'b0, "R8 unexpected out_valid", {31'b0, out_valid}, 32'h0);
                    end else begin
                        logic [31:0] er;
                        logic        ei;
                        string       tg;
                        er = exp_res_q.pop_front();
                        ei = exp_inv_q.pop_front();
                        tg = tag_q.pop_front();
                        check(out_res == er, {tg, " result"}, out_res, er);
                        check(out_invalid == ei, {"R7 invalid for ", tg}, {31'b0, out_invalid}, {31'b0, ei});
                        last_res = er;
                        last_inv = ei;
                    end
                end else begin
                    check(exp_res_q.size() == 0, "R8 missing out_valid", 32'h0, 32'h1);
                    check(out_res == last_res && out_invalid == last_inv, "R9 hold", out_res, last_res);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_res == '0 && out_invalid == 1'b0, "R10 reset", out_res, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R1 NaN inputs
        send(32'h7FC0_0000, 32'h7FC0_0000, 1'b0, "R1 qnan");
        send(32'h7F80_0001, 32'h7FC0_0000, 1'b1, "R1 snan");
        send(32'hFFC0_0000, 32'h7FC0_0000, 1'b0, "R1 neg qnan");
        // R2 zero / denormal
        send(32'h0000_0000, 32'h7F80_0000, 1'b0, "R2 +0");
        send(32'h8000_0000, 32'hFF80_0000, 1'b0, "R2 -0");
        send(32'h0000_0001, 32'h7F80_0000, 1'b0, "R2 +denorm");
        send(32'h8040_0000, 32'hFF80_0000, 1'b0, "R2 -denorm");
        idle(3);
        // R3 negative
        send(32'hBF80_0000, 32'h7FC0_0004, 1'b1, "R3 -1.0");
        send(32'hFF80_0000, 32'h7FC0_0004, 1'b1, "R3 -inf");
        // R4
        send(32'h7F80_0000, 32'h0000_0000, 1'b0, "R4 +inf");
        idle(2);
        // R5 / R6 normal positive
        send(32'h3F80_0000, 32'h3F7E_8000, 1'b0, "R5 R6 1.0 idx0");
        send(32'h4000_0000, 32'h3F33_8000, 1'b0, "R5 R6 2.0 idx64");
        send(32'h4080_0000, 32'h3EFE_8000, 1'b0, "R5 4.0 even parity");
        send(32'h0080_0000, 32'h5EFE_8000, 1'b0, "R5 min normal");
        send(32'h7F7F_FFFF, 32'h1F81_0000, 1'b0, "R5 R6 max normal idx127");
        send(32'h3FFE_0000, 32'h3F36_0000, 1'b0, "R6 idx63");
        send(32'h3F82_0000, 32'h3F7E_0000, 1'b0, "R6 idx1");
        send(32'h3F84_0000, 32'h3F7A_8000, 1'b0, "R6 idx2");
        send(32'h3F86_0000, 32'h3F7A_0000, 1'b0, "R6 idx3");
        send(32'h3FE0_0000, 32'h3F41_8000, 1'b0, "R6 idx48");
        send(32'h4002_0000, 32'h3F33_0000, 1'b0, "R6 idx65");
        send(32'h407C_0000, 32'h3F01_8000, 1'b0, "R6 idx126");
        idle(4);
        send(32'h3F80_0000, 32'h3F7E_8000, 1'b0, "R8 single after gap");
        idle(4);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule